// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a local copy of the contents of a one-time-programmable fuse array. The bus reads that copy instead of the slow fuse macro. After power-up, or after new fuses have been blown, software starts a reload. The block then walks the fuse array, one word per cycle, and refreshes every shadow word. Before it copies the words, it fetches one dedicated lock word. That word sets which groups of words are read-locked and which are write-locked.

Every access that breaks a rule sets a sticky error flag. The rules are:
- A shadow write that arrives while a reload is running.
- A write to a write-locked word.
- A read of a read-locked word. That read returns the fixed pattern 0xBADABADA.

While the flag is set, the bank refuses further shadow reads, writes and reload starts. Software clears the flag through a clear alias of the control register.

The bus side is a request stream with valid/ready. `req_ready` is tied high, so the block never applies back-pressure. Every accepted read produces exactly one response one cycle later on `rsp_valid`/`rsp_rdata`. The response carries no ready, so the consumer must take it in that cycle. Writes produce no response.

Top module: `fuse_shadow_bank`

## Requirements
- R1: After reset `reload_busy` and `error_flag` are low, every shadow word reads 0, and the lock state is all clear, so no word is locked.
- R2: Word i sits at byte offset 0x400 + 0x10*i. The status register at offset 0x000 reads back bit 8 = busy, bit 9 = error, bit 10 = reload in progress, and zero elsewhere.
- R3: Writing a word with bit 10 set to offset 0x004 starts a reload. `reload_busy` (and status bit 10) stays high for exactly NWORDS+2 cycles and then clears by itself. Afterwards every shadow word equals its fuse word.
- R4: A reload first fetches fuse word LOCK_IDX into the lock state and only then copies the words. In that lock word, bit g (g < 16) write-locks group g and bit 16+g read-locks group g, where group = index / (NWORDS/16).
- R5: A shadow write accepted during a reload sets the error flag and leaves the word unchanged.
- R6: A shadow write to a write-locked word sets the error flag and leaves the word unchanged.
- R7: A read of a read-locked word returns 0xBADABADA and sets the error flag.
- R8: The error flag is sticky. While it is set:
  - shadow reads return 0;
  - shadow writes are dropped;
  - reload starts are ignored.
  It clears only when a word with bit 9 set is written to offset 0x008.
- R9: Reads of unlocked words during a reload are not stalled. They return the word currently held in the shadow.
- R10: Offsets inside the shadow window that are not a word slot, and unmapped offsets, read as 0 and do not set the error flag. Writes to them have no effect.
- R11: Outside a reload, a write to an unlocked word updates it and a later read returns the new value.
- R12: `req_ready` is always high. Each accepted read raises `rsp_valid` for exactly the next cycle. Accepted writes raise no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | 32 | Read response data |
| fuse_rd_en | output | 1 | Fuse array read strobe |
| fuse_rd_addr | output | IDX_W | Fuse word index |
| fuse_rd_data | input | 32 | Fuse word, one cycle after the strobe |
| reload_busy | output | 1 | Reload in progress |
| error_flag | output | 1 | Sticky access-violation flag |

## Verification
The bench runs a 16-word bank, so each lock bit guards exactly one word, and sweeps every word for reads and writes under two different lock words. A design that copied the lock word from the shadow rather than from the fuses, or that kept stale locks across a reload, would poison the wrong words on the second sweep. A late write probe re-writes a word the reload has already refreshed. That probe catches a bank that lets writes through during a reload, because the stray value would survive. The bench also counts the exact busy length and probes the in-between offsets of the window, where a decoder that ignores the low address bits would alias onto real words. Finally, it exercises every operation while the error flag is up, and a bank that kept serving reads or accepted a reload there would differ at the ports.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [2:0] {
    AK_NONE,
    AK_STAT,
    AK_SET,
    AK_CLR,
    AK_SLOT,
    AK_HOLE
  } acc_kind_t;

  localparam logic [31:0] POISON_WORD = 32'hBADA_BADA;
  localparam int          ST_BUSY     = 8;
  localparam int          ST_ERR      = 9;
  localparam int          ST_RELOAD   = 10;
  localparam logic [31:0] OFS_STAT    = 32'h000;
  localparam logic [31:0] OFS_SET     = 32'h004;
  localparam logic [31:0] OFS_CLR     = 32'h008;
  localparam logic [31:0] WIN_LO      = 32'h400;
  localparam int          SLOT_SHIFT  = 4;
endpackage

// File: rtl/ocs_addr_decode.sv
module ocs_addr_decode
  import ocs_pkg::*;
#(
  parameter int NWORDS = 128,
  parameter int ADDR_W = 12,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_t         kind,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [31:0] WIN_HI = WIN_LO + 32'(NWORDS << SLOT_SHIFT);

  logic [31:0] a32;

  always_comb begin
    a32  = 32'(addr);
    idx  = addr[IDX_W+SLOT_SHIFT-1:SLOT_SHIFT] - WIN_LO[IDX_W+SLOT_SHIFT-1:SLOT_SHIFT];
    kind = AK_NONE;
    if (a32 == OFS_STAT)      kind = AK_STAT;
    else if (a32 == OFS_SET)  kind = AK_SET;
    else if (a32 == OFS_CLR)  kind = AK_CLR;
    else if (a32 >= WIN_LO && a32 < WIN_HI)
      kind = (addr[SLOT_SHIFT-1:0] == '0) ? AK_SLOT : AK_HOLE;
  end
endmodule

// File: rtl/ocs_lock_check.sv
module ocs_lock_check #(
  parameter int NWORDS = 128,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int GRP_W = $clog2(NWORDS / 16)
) (
  input  logic [31:0]      lock_word,
  input  logic [IDX_W-1:0] idx,
  output logic             wr_locked,
  output logic             rd_locked
);
  logic [15:0] wl, rl;
  assign wl = lock_word[15:0];
  assign rl = lock_word[31:16];

  always_comb begin
    wr_locked = 1'b0;
    rd_locked = 1'b0;
    for (int g = 0; g < 16; g++) begin
      if ((idx >> GRP_W) == IDX_W'(g)) begin
        wr_locked = wl[g];
        rd_locked = rl[g];
      end
    end
  end
endmodule

// File: rtl/ocs_reload_seq.sv
module ocs_reload_seq #(
  parameter int NWORDS   = 128,
  parameter int LOCK_IDX = 0,
  localparam int IDX_W   = $clog2(NWORDS),
  localparam int LEN_W   = IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             fuse_rd_en,
  output logic [IDX_W-1:0] fuse_rd_addr,
  output logic             cap_valid,
  output logic             cap_lock,
  output logic [IDX_W-1:0] cap_idx,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);
  localparam logic [IDX_W-1:0] LIDX = IDX_W'(LOCK_IDX);

  logic             active, lock_phase;
  logic [IDX_W-1:0] iss_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      lock_phase <= 1'b0;
      iss_idx    <= '0;
      cap_valid  <= 1'b0;
      cap_lock   <= 1'b0;
      cap_idx    <= '0;
    end else begin
      cap_valid <= active;
      cap_lock  <= lock_phase;
      cap_idx   <= iss_idx;
      if (!active) begin
        if (start) begin
          active     <= 1'b1;
          lock_phase <= 1'b1;
          iss_idx    <= '0;
        end
      end else if (lock_phase) begin
        lock_phase <= 1'b0;
      end else if (iss_idx == LAST) begin
        active <= 1'b0;
      end else begin
        iss_idx <= iss_idx + 1'b1;
      end
    end
  end

  assign fuse_rd_en   = active;
  assign fuse_rd_addr = lock_phase ? LIDX : iss_idx;
  assign busy         = active | cap_valid;

  logic [LEN_W-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R3
  reload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == LEN_W'(NWORDS + 2));

  // R4
  lock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_valid) |-> cap_lock);
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank
  import ocs_pkg::*;
#(
  parameter int NWORDS   = 128,
  parameter int LOCK_IDX = 0,
  parameter int ADDR_W   = 12,
  localparam int IDX_W   = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              fuse_rd_en,
  output logic [IDX_W-1:0]  fuse_rd_addr,
  input  logic [31:0]       fuse_rd_data,
  output logic              reload_busy,
  output logic              error_flag
);
  acc_kind_t        kind;
  logic [IDX_W-1:0] idx;
  logic             wlock, rlock;
  logic [31:0]      lock_q;
  logic             err_q;
  logic             cap_valid, cap_lock;
  logic [IDX_W-1:0] cap_idx;
  logic             busy;
  logic [31:0]      mem [NWORDS];

  ocs_addr_decode #(.NWORDS(NWORDS), .ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .kind (kind),
    .idx  (idx)
  );

  ocs_lock_check #(.NWORDS(NWORDS)) u_lock (
    .lock_word (lock_q),
    .idx       (idx),
    .wr_locked (wlock),
    .rd_locked (rlock)
  );

  logic acc, is_rd, is_wr, start, clr, err_set, mem_we;
  logic [31:0] status, rd_val;

  assign req_ready = 1'b1;
  assign acc       = req_valid & req_ready;
  assign is_rd     = acc & ~req_write;
  assign is_wr     = acc & req_write;

  always_comb begin
    start   = is_wr && kind == AK_SET && req_wdata[ST_RELOAD] && !err_q && !busy;
    clr     = is_wr && kind == AK_CLR && req_wdata[ST_ERR];
    err_set = !err_q && kind == AK_SLOT &&
              ((is_wr && (busy || wlock)) || (is_rd && rlock));
    mem_we  = is_wr && kind == AK_SLOT && !err_q && !busy && !wlock;
    status  = '0;
    status[ST_BUSY]   = busy;
    status[ST_ERR]    = err_q;
    status[ST_RELOAD] = busy;
    unique case (kind)
      AK_STAT, AK_SET, AK_CLR: rd_val = status;
      AK_SLOT: rd_val = err_q ? 32'h0 : (rlock ? POISON_WORD : mem[idx]);
      default: rd_val = 32'h0;
    endcase
  end

  ocs_reload_seq #(.NWORDS(NWORDS), .LOCK_IDX(LOCK_IDX)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .fuse_rd_en   (fuse_rd_en),
    .fuse_rd_addr (fuse_rd_addr),
    .cap_valid    (cap_valid),
    .cap_lock     (cap_lock),
    .cap_idx      (cap_idx),
    .busy         (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q     <= 1'b0;
      lock_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (clr)          err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
      if (cap_valid && cap_lock) lock_q <= fuse_rd_data;
      rsp_valid <= is_rd;
      if (is_rd) rsp_rdata <= rd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (cap_valid && !cap_lock) begin
      mem[cap_idx] <= fuse_rd_data;
    end else if (mem_we) begin
      mem[idx] <= req_wdata;
    end
  end

  assign reload_busy = busy;
  assign error_flag  = err_q;

  // R5
  busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && kind == AK_SLOT && reload_busy) |=> error_flag);

  // R7
  poison_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && kind == AK_SLOT && !error_flag && rlock) |=>
      (rsp_rdata == POISON_WORD && error_flag));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (error_flag && !(is_wr && kind == AK_CLR)) |=> error_flag);

  // R8
  no_start_in_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reload_busy) |-> !$past(error_flag));

  // R10
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && kind == AK_HOLE) |=> (rsp_rdata == 32'h0 && $stable(error_flag)));

  // R12
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rsp_valid);

  // R12
  no_rsp_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rsp_valid);
endmodule

// File: tb/test_fuse_shadow_bank.sv
module test_fuse_shadow_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NW   = 16;
  localparam int LIDX = 3;
  localparam int AW   = 12;
  localparam int IW   = $clog2(NW);
  localparam logic [31:0] POISON = 32'hBADA_BADA;
  localparam logic [31:0] LOCKW1 = 32'h1084_0222; // wr-lock 1,5,9; rd-lock 2,7,12
  localparam logic [31:0] LOCKW2 = 32'h0100_0010; // wr-lock 4; rd-lock 8

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, fuse_rd_en, reload_busy, error_flag;
  logic [31:0] rsp_rdata, fuse_q;
  logic [IW-1:0] fuse_rd_addr;
  logic [31:0] lock_cur = LOCKW1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_shadow_bank #(.NWORDS(NW), .LOCK_IDX(LIDX), .ADDR_W(AW)) i_fuse_shadow_bank (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .fuse_rd_en, .fuse_rd_addr, .fuse_rd_data(fuse_q),
    .reload_busy, .error_flag
  );

  function automatic logic [31:0] fuse_val(int i);
    if (i == LIDX) return lock_cur;
    return (32'(i) * 32'h0103_0507) ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) if (fuse_rd_en) fuse_q <= fuse_val(int'(fuse_rd_addr));

  function automatic logic [AW-1:0] waddr(int i);
    return AW'(32'h400 + 16 * i);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(logic [AW-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  task automatic clear_err();
    bus_wr(AW'(12'h008), 32'h0000_0200);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (reload_busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic sweep_reads(logic [31:0] lw, string tag);
    logic [31:0] d; logic v;
    for (int i = 0; i < NW; i++) begin
      bus_rd(waddr(i), d, v);
      if (lw[16+i]) begin
        chk(d == POISON && error_flag, {tag, " R7 poison"}, d, POISON);
        clear_err();
        chk(!error_flag, "R8 clear", 32'(error_flag), 0);
      end else begin
        chk(d == fuse_val(i) && !error_flag && v, {tag, " R3 word"}, d, fuse_val(i));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic v; int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!reload_busy && !error_flag, "R1 pins", {30'd0, reload_busy, error_flag}, 0);
    chk(req_ready, "R12 ready", 32'(req_ready), 1);
    bus_rd(waddr(5), d, v);
    chk(d == 0 && v, "R1 word zero", d, 0);
    bus_rd(AW'(0), d, v);
    chk(d == 0, "R2 status idle", d, 0);
    bus_rd(waddr(2), d, v);
    chk(d == 0 && !error_flag, "R1 no lock", d, 0);
    // R11 write before reload
    bus_wr(waddr(1), 32'hCAFE_0001);
    chk(!error_flag, "R11 no err", 32'(error_flag), 0);
    bus_rd(waddr(1), d, v);
    chk(d == 32'hCAFE_0001, "R11 readback", d, 32'hCAFE_0001);
    // R3 reload #1
    bus_wr(AW'(12'h004), 32'h0000_0400);
    wait_idle(n);
    chk(n == NW + 2, "R3 busy length", 32'(n), NW + 2);
    sweep_reads(LOCKW1, "L1");
    // R6 / R11 write sweep
    for (int i = 0; i < NW; i++) begin
      bus_wr(waddr(i), 32'h7700_0000 | 32'(i));
      if (LOCKW1[i]) begin
        chk(error_flag, "R6 wlock err", 32'(error_flag), 1);
        clear_err();
      end else begin
        chk(!error_flag, "R11 write ok", 32'(error_flag), 0);
      end
      bus_rd(waddr(i), d, v);
      if (LOCKW1[16+i]) begin
        chk(d == POISON, "R7 poison after write", d, POISON);
        clear_err();
      end else if (LOCKW1[i]) begin
        chk(d == fuse_val(i), "R6 unchanged", d, fuse_val(i));
      end else begin
        chk(d == (32'h7700_0000 | 32'(i)), "R11 new value", d, 32'h7700_0000 | 32'(i));
      end
    end
    // R10 holes
    for (int off = 4; off < 16; off += 4) begin
      bus_rd(AW'(32'h420 + off), d, v);
      chk(d == 0 && !error_flag && v, "R10 hole read", d, 0);
    end
    bus_rd(AW'(12'h500), d, v);
    chk(d == 0 && !error_flag, "R10 beyond window", d, 0);
    bus_rd(AW'(12'h00C), d, v);
    chk(d == 0, "R10 unmapped", d, 0);
    bus_wr(AW'(12'h464), 32'hFFFF_FFFF);
    chk(!error_flag, "R10 hole write no err", 32'(error_flag), 0);
    bus_rd(waddr(6), d, v);
    chk(d == 32'h7700_0006, "R10 hole write no effect", d, 32'h7700_0006);
    // R8 blocking while error
    bus_wr(waddr(5), 32'h1);
    chk(error_flag, "R6 wlock err", 32'(error_flag), 1);
    bus_rd(waddr(0), d, v);
    chk(d == 0 && v, "R8 read blocked", d, 0);
    bus_wr(waddr(0), 32'h1111_1111);
    bus_wr(AW'(12'h004), 32'h0000_0400);
    chk(!reload_busy, "R8 reload ignored", 32'(reload_busy), 0);
    bus_rd(AW'(0), d, v);
    chk(d == 32'h200, "R2 status err", d, 32'h200);
    clear_err();
    chk(!error_flag, "R8 cleared", 32'(error_flag), 0);
    bus_rd(waddr(0), d, v);
    chk(d == 32'h7700_0000, "R8 write dropped", d, 32'h7700_0000);
    // reload #2 with new lock word
    lock_cur = LOCKW2;
    bus_wr(AW'(12'h004), 32'h0000_0400);
    bus_rd(AW'(0), d, v);
    chk(d == 32'h500, "R2 status busy", d, 32'h500);
    repeat (8) @(negedge clk);
    bus_rd(waddr(0), d, v);
    chk(v && reload_busy && d == fuse_val(0), "R9 read during reload", d, fuse_val(0));
    bus_wr(waddr(0), 32'h2222_2222);
    chk(error_flag && reload_busy, "R5 busy write err", 32'(error_flag), 1);
    wait_idle(n);
    clear_err();
    bus_rd(waddr(0), d, v);
    chk(d == fuse_val(0), "R5 unchanged", d, fuse_val(0));
    // R4 new locks
    sweep_reads(LOCKW2, "L2");
    bus_wr(waddr(4), 32'h3);
    chk(error_flag, "R4 new wlock", 32'(error_flag), 1);
    clear_err();
    bus_wr(waddr(5), 32'h5555_0005);
    chk(!error_flag, "R4 old wlock gone", 32'(error_flag), 0);
    bus_rd(waddr(5), d, v);
    chk(d == 32'h5555_0005, "R4 word5 writable", d, 32'h5555_0005);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule